// File: doc/BRIEF.md
# Table-Driven Sequencer with ROM Feedback

This block is a finite state machine in which all next-state and output decisions come from one read-only lookup table. Each clock, the current state code and the external condition inputs are joined into a table address. The word read from that address holds the next state code and a set of free output bits. The read is synchronous, so the registered table word is also the state register. The state field is fed back to the address, and both fields are driven to the ports.

The table is built at elaboration by a constant function, so every address has a defined entry. The default geometry has five state bits, four condition bits and three free output bits: 512 words of 8 bits. Codes 0 to `LIVE_STATES-1` are the working states. The all-ones code is a parking state. Every code between the two is filled with a return to code 0.

A parameter selects how the table is stored. It can be an indexed constant array, or the same constant function evaluated on the address. The behaviour at the ports is the same for both.

Top module: `fsm_rom_seq`

## Requirements
- R1: A clock edge with `rst` high forces `state_o` to 0 and `out_o` to 0. After `rst` falls, the machine continues from code 0.
- R2: `state_o` and `out_o` change only at a rising clock edge. They show the table word for the state and `cond_i` sampled at that edge. A change on `cond_i` between edges leaves the outputs unchanged.
- R3: In working state s (s < `LIVE_STATES`, default 24) with condition c below all-ones-minus-one, the next state is (s + c + 1) mod `LIVE_STATES`. `out_o` becomes the low `OUT_BITS` bits of s XOR c.
- R4: In a working state with `cond_i` all ones (15 by default), the next state is 0 and `out_o` is 0.
- R5: In a working state with `cond_i` equal to all ones minus one (14 by default), the next state is the parking code, all ones on `state_o` (31 by default), and `out_o` is 0.
- R6: From the parking code, every `cond_i` value leads to state 0, and `out_o` becomes all ones (7 by default). This rule takes priority over R3 to R5.
- R7: `state_o` never shows a code from `LIVE_STATES` up to parking minus one. Each of those codes maps to state 0 with `out_o` 0 for every condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | IN_BITS | External condition inputs, low part of the table address |
| state_o | output | STATE_BITS | Registered state field of the table word |
| out_o | output | OUT_BITS | Registered free output field of the table word |

## Verification
The state code is visible on `state_o`, so a wrong table entry or a broken feedback path shows at the port one edge after the faulty lookup. Because the state feeds the next address, that single error also moves every later transition onto a different path, and `out_o` diverges along with it. The bench drives walks of several step sizes, the abort and parking paths, and a resets in the middle of a run. It also drives a long pseudo-random stream that keeps checking each transition against a model of the rules. A reset fault shows on the first edge after `rst` rises.

// File: rtl/fsm_rom_pkg.sv
package fsm_rom_pkg;

   // Table rule for one (state, condition) pair.
   // Returned word: next state in the upper bits, free outputs in the low OB bits.
   function automatic logic [31:0] fsm_entry(input int s, input int c, input int sb,
                                             input int ib, input int ob, input int live);
      int park;
      int cmax;
      int nxt;
      int o;
      park = (1 << sb) - 1;
      cmax = (1 << ib) - 1;
      if (s == park) begin
         nxt = 0;
         o   = (1 << ob) - 1;
      end else if (s >= live) begin
         nxt = 0;
         o   = 0;
      end else if (c == cmax) begin
         nxt = 0;
         o   = 0;
      end else if (c == cmax - 1) begin
         nxt = park;
         o   = 0;
      end else begin
         nxt = (s + c + 1) % live;
         o   = (s ^ c) & ((1 << ob) - 1);
      end
      return 32'((nxt << ob) | o);
   endfunction

endpackage

// File: rtl/fsm_rom_addr.sv
module fsm_rom_addr #(
   parameter int STATE_BITS = 5,
   parameter int IN_BITS    = 4,
   localparam int ADDR_W    = STATE_BITS + IN_BITS
) (
   input  logic [STATE_BITS-1:0] state_i,
   input  logic [IN_BITS-1:0]    cond_i,
   output logic [ADDR_W-1:0]     addr_o
);

   // State in the high bits, conditions in the low bits.
   assign addr_o = {state_i, cond_i};

endmodule

// File: rtl/fsm_rom_table.sv
module fsm_rom_table #(
   parameter int STATE_BITS  = 5,
   parameter int IN_BITS     = 4,
   parameter int OUT_BITS    = 3,
   parameter int LIVE_STATES = 24,
   parameter int ROM_STYLE   = 0,
   localparam int ADDR_W     = STATE_BITS + IN_BITS,
   localparam int WORD_W     = STATE_BITS + OUT_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] word_q
);
   import fsm_rom_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;

   typedef logic [WORD_W-1:0] rom_t [DEPTH];

   function automatic rom_t build_rom();
      rom_t t;
      for (int a = 0; a < DEPTH; a++) begin
         t[a] = WORD_W'(fsm_entry(a >> IN_BITS, a & ((1 << IN_BITS) - 1),
                                  STATE_BITS, IN_BITS, OUT_BITS, LIVE_STATES));
      end
      return t;
   endfunction

   logic [WORD_W-1:0] rd_word;

   generate
      if (ROM_STYLE == 0) begin : g_array
         localparam rom_t ROM = build_rom();
         assign rd_word = ROM[addr_i];
      end else begin : g_calc
         assign rd_word = WORD_W'(fsm_entry(int'(addr_i[ADDR_W-1:IN_BITS]),
                                            int'(addr_i[IN_BITS-1:0]),
                                            STATE_BITS, IN_BITS, OUT_BITS, LIVE_STATES));
      end
   endgenerate

   // Synchronous read; the registered word is the machine's state.
   always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= rd_word;
   end

endmodule

// File: rtl/fsm_rom_seq.sv
module fsm_rom_seq #(
   parameter int STATE_BITS  = 5,
   parameter int IN_BITS     = 4,
   parameter int OUT_BITS    = 3,
   parameter int LIVE_STATES = 24,
   parameter int ROM_STYLE   = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [IN_BITS-1:0]    cond_i,
   output logic [STATE_BITS-1:0] state_o,
   output logic [OUT_BITS-1:0]   out_o
);

   localparam int ADDR_W = STATE_BITS + IN_BITS;
   localparam int WORD_W = STATE_BITS + OUT_BITS;
   localparam int PARK   = (1 << STATE_BITS) - 1;
   localparam int CMAX   = (1 << IN_BITS) - 1;

   generate
      if (IN_BITS < 2) begin : g_bad_in
         $error("IN_BITS must be at least 2");
      end
      if (OUT_BITS < 1) begin : g_bad_out
         $error("OUT_BITS must be at least 1");
      end
      if (WORD_W > 32) begin : g_bad_word
         $error("STATE_BITS + OUT_BITS must not exceed 32");
      end
      if (LIVE_STATES < 1 || LIVE_STATES > PARK) begin : g_bad_live
         $error("LIVE_STATES must lie in 1 .. 2**STATE_BITS-1");
      end
      if (ROM_STYLE != 0 && ROM_STYLE != 1) begin : g_bad_style
         $error("ROM_STYLE must be 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr;
   logic [WORD_W-1:0] word_q;

   fsm_rom_addr #(
      .STATE_BITS(STATE_BITS),
      .IN_BITS   (IN_BITS)
   ) i_addr (
      .state_i(state_o),
      .cond_i (cond_i),
      .addr_o (addr)
   );

   fsm_rom_table #(
      .STATE_BITS (STATE_BITS),
      .IN_BITS    (IN_BITS),
      .OUT_BITS   (OUT_BITS),
      .LIVE_STATES(LIVE_STATES),
      .ROM_STYLE  (ROM_STYLE)
   ) i_table (
      .clk   (clk),
      .rst   (rst),
      .addr_i(addr),
      .word_q(word_q)
   );

   assign state_o = word_q[WORD_W-1:OUT_BITS];
   assign out_o   = word_q[OUT_BITS-1:0];

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (state_o == '0 && out_o == '0));  // R1

   AST_NO_DEAD_CODE: assert property (@(posedge clk) disable iff (rst)
      (int'(state_o) < LIVE_STATES || int'(state_o) == PARK));  // R7

   AST_STEP_RULE: assert property (@(posedge clk) disable iff (rst)
      (int'(state_o) < LIVE_STATES && int'(cond_i) < CMAX - 1) |=>
      (int'(state_o) == (int'($past(state_o)) + int'($past(cond_i)) + 1) % LIVE_STATES));  // R3

   AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (int'(state_o) < LIVE_STATES && int'(cond_i) == CMAX) |=>
      (state_o == '0 && out_o == '0));  // R4

   AST_PARK_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (int'(state_o) < LIVE_STATES && int'(cond_i) == CMAX - 1) |=>
      (int'(state_o) == PARK));  // R5

   AST_PARK_EXIT: assert property (@(posedge clk) disable iff (rst)
      (int'(state_o) == PARK) |=> (state_o == '0 && out_o == '1));  // R6

endmodule

// File: tb/test_fsm_rom_seq.sv
`timescale 1ns/1ps
module test_fsm_rom_seq;

   localparam int SB   = 5;
   localparam int IB   = 4;
   localparam int OB   = 3;
   localparam int LIVE = 24;
   localparam int PARK = 31;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IB-1:0] cond = '0;
   logic [SB-1:0] state_o;
   logic [OB-1:0] out_o;

   int checks = 0;
   int errors = 0;
   int ms     = 0;   // model state
   int mo     = 0;   // model output

   int    q_state[$];
   int    q_out[$];
   string q_tag[$];

   always #10 clk = ~clk;   // 50 MHz

   fsm_rom_seq i_fsm_rom_seq (
      .clk    (clk),
      .rst    (rst),
      .cond_i (cond),
      .state_o(state_o),
      .out_o  (out_o)
   );

   // Reference model written straight from the requirements.
   task automatic model(input int s, input int c, output int ns, output int no,
                        output string tag);
      if (s == PARK) begin
         ns = 0;  no = 7;  tag = "R6";
      end else if (c == 15) begin
         ns = 0;  no = 0;  tag = "R4";
      end else if (c == 14) begin
         ns = PARK; no = 0; tag = "R5";
      end else begin
         ns = (s + c + 1) % LIVE;
         no = (s ^ c) % 8;
         tag = "R3";
      end
   endtask

   task automatic check(input string tag, input int act_s, input int act_o,
                        input int exp_s, input int exp_o);
      checks++;
      if (act_s != exp_s || act_o != exp_o) begin
         errors++;
         $display("FAIL %s: state/out actual %0d/%0d expected %0d/%0d",
                  tag, act_s, act_o, exp_s, exp_o);
      end
   endtask

   task automatic step(input int c);
      int ns;
      int no;
      string tag;
      @(negedge clk);
      rst  = 1'b0;
      cond = IB'(c);
      #1;
      // R2: a new condition has no effect before the next edge
      check("R2", int'(state_o), int'(out_o), ms, mo);
      model(ms, c, ns, no, tag);
      q_state.push_back(ns);
      q_out.push_back(no);
      q_tag.push_back(tag);
      ms = ns;
      mo = no;
   endtask

   task automatic reset_cycle();
      @(negedge clk);
      rst = 1'b1;
      q_state.push_back(0);
      q_out.push_back(0);
      q_tag.push_back("R1");
      ms = 0;
      mo = 0;
   endtask

   // Monitor: compare each registered result shortly after its edge.
   always @(posedge clk) begin
      #5;
      if (q_state.size() > 0) begin
         int es;
         int eo;
         string t;
         es = q_state.pop_front();
         eo = q_out.pop_front();
         t  = q_tag.pop_front();
         check(t, int'(state_o), int'(out_o), es, eo);
         if (!rst && int'(state_o) >= LIVE && int'(state_o) != PARK) begin
            checks++;
            errors++;
            $display("FAIL R7: state actual %0d expected a live or parking code",
                     int'(state_o));
         end
      end
   end

   initial begin
      logic [7:0] lfsr;
      reset_cycle();
      reset_cycle();
      // R3: unit-step walk wrapping past LIVE-1
      for (int i = 0; i < 30; i++) step(0);
      // R3: every ordinary step size
      for (int c = 1; c < 14; c++) step(c);
      // R4: abort from a working state
      step(5);
      step(15);
      // R5 then R6: enter and leave parking
      step(3);
      step(14);
      step(0);
      step(14);
      step(15);   // R6 priority over abort
      step(14);
      step(14);   // R6 priority over park entry
      // R1: reset in the middle of a run, then resume from 0
      step(7);
      step(9);
      reset_cycle();
      step(2);
      // Long pseudo-random stream covering all rules
      lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(int'(lfsr[3:0]));
      end
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R2: watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule